// File: doc/BRIEF.md
# Product-Term Logic Macrocell

This block is a soft model of a single programmable-logic macrocell. A small array of input signals feeds five product terms. Each term is the AND of literals picked per input (true form, complemented form, or not used). A static role code sends each term either into the sum path or to one control function of the output register: a second data input, an array clock, a clock enable, an asynchronous preset or an asynchronous clear. The sum path ORs every term given the sum role, and a configuration bit can then invert the result through an XOR.

The output register runs as a D, T, JK or SR element, or it is bypassed so that the sum drives the output directly. It is clocked by one of two global clocks, by a global clock gated with an enable term, or by an array clock built from product terms. Each global clock is the true or the inverted form of one of two dedicated clock pins. The model runs on a fast system clock, and the register updates on the system edge that first sees the selected clock high after seeing it low. Asynchronous preset and clear override the register at once. An active-low global clear pin can also clear it when the configuration allows. All configuration is captured while the reset is held and stays frozen after that.

Top module: `mc_macrocell`

## Requirements
- R1: Term t, input i has a 2-bit literal code at cfg_lit[t*2*N_IN + 2*i +: 2]: 00 = input unused, 01 = true form, 10 = complement, 11 = forces the term to 0. A term with no literal used evaluates to 1.
- R2: Term t has a 3-bit role at cfg_role[3*t +: 3]: 0 = sum, 1 = second data input (K/R), 2 = array clock, 3 = clock enable, 4 = preset, 5 = clear, 6 and 7 = unused. Terms that share a role are ORed together. A role that no term holds reads as 0, except the enable, which then reads as 1.
- R3: When cfg_xor is 1, the sum is inverted before it reaches the register or the output.
- R4: cfg_mode 0 (and the spare codes 5 to 7) bypasses the register, so mc_out follows the sum combinationally.
- R5: cfg_mode 1 (D): on a clock update the register loads the sum.
- R6: cfg_mode 2 (T): on a clock update the register toggles when the sum is 1 and holds otherwise.
- R7: cfg_mode 3 (JK): J is the sum and K is the second-data-input role. 10 sets, 01 clears, 00 holds and 11 toggles.
- R8: cfg_mode 4 (SR): S is the sum and R is the second-data-input role. 10 sets, 01 clears, and both 00 and 11 hold.
- R9: Global clock g is gclk_pin[cfg_gpin[g]] XOR cfg_ginv[g], and cfg_gsel picks g. With cfg_clk_src 0, the register updates on the first system edge that sees the selected clock at 1 after having seen it at 0. A clock that is already high when reset is released gives no update, and a clock held high gives exactly one update.
- R10: With cfg_clk_src 1, a global clock edge updates the register only while the enable role reads 1.
- R11: With cfg_clk_src 2 or 3, the clock is the array clock role, and the global clock pins have no effect.
- R12: In registered modes the preset and clear roles act at once and asynchronously. Clear forces 0, preset forces 1, and clear wins when both are active. The register keeps the forced value after release.
- R13: When cfg_gclr_en is 1, a low gclr_n clears the register like the clear role. When cfg_gclr_en is 0, gclr_n has no effect.
- R14: All cfg_* inputs are captured only while rst_n is low, and changes made after that are ignored. The register is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample every input |
| rst_n | input | 1 | Active-low reset; configuration is loaded while it is low |
| arr_in | input | N_IN | Array inputs feeding the product terms |
| gclk_pin | input | 2 | Dedicated global clock pins |
| gclr_n | input | 1 | Dedicated active-low global clear |
| cfg_lit | input | NUM_TERMS*2*N_IN | Literal codes for every term |
| cfg_role | input | NUM_TERMS*3 | Role code for every term |
| cfg_xor | input | 1 | Sum polarity inversion |
| cfg_mode | input | 3 | Register mode or bypass |
| cfg_clk_src | input | 2 | Clock source: global, gated global, array |
| cfg_gpin | input | 2 | Pin chosen for each global clock |
| cfg_ginv | input | 2 | Inversion for each global clock |
| cfg_gsel | input | 1 | Which global clock the register uses |
| cfg_gclr_en | input | 1 | Allows gclr_n to clear the register |
| mc_out | output | 1 | Macrocell output |

## Verification
The bench uses the default build, N_IN = 8 and NUM_TERMS = 5. Eight inputs let every role have its own input, so the data, enable, clock, preset and clear terms can be driven separately inside one configuration. Five terms allow a sum term, a K/R term and up to three control terms to be active together. The pairs of array clock terms and of preset plus clear can therefore be exercised without reconfiguring between steps.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int ROLE_W   = 3;
  localparam int NUM_GCLK = 2;

  typedef enum logic [2:0] {
    MODE_COMB = 3'd0,
    MODE_D    = 3'd1,
    MODE_T    = 3'd2,
    MODE_JK   = 3'd3,
    MODE_SR   = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    ROLE_SUM = 3'd0,
    ROLE_AUX = 3'd1,
    ROLE_CLK = 3'd2,
    ROLE_EN  = 3'd3,
    ROLE_PRE = 3'd4,
    ROLE_CLR = 3'd5
  } role_e;

  typedef enum logic [1:0] {
    SRC_GLOBAL = 2'd0,
    SRC_GATED  = 2'd1,
    SRC_ARRAY  = 2'd2
  } clksrc_e;

  // True for the four register modes; any other code bypasses the register.
  function automatic logic is_registered(input logic [2:0] m);
    return (m == MODE_D) || (m == MODE_T) || (m == MODE_JK) || (m == MODE_SR);
  endfunction

  // Next register value from the primary input a, the secondary input b and the current q.
  function automatic logic next_state(input logic [2:0] m, input logic a,
                                      input logic b, input logic q);
    logic nq;
    nq = q;
    case (m)
      MODE_D:  nq = a;
      MODE_T:  nq = q ^ a;
      MODE_JK: begin
        case ({a, b})
          2'b10:   nq = 1'b1;
          2'b01:   nq = 1'b0;
          2'b11:   nq = ~q;
          default: nq = q;
        endcase
      end
      MODE_SR: begin
        case ({a, b})
          2'b10:   nq = 1'b1;
          2'b01:   nq = 1'b0;
          default: nq = q;
        endcase
      end
      default: nq = q;
    endcase
    return nq;
  endfunction

endpackage

// File: rtl/mc_term.sv
module mc_term #(
  parameter int N_IN = 8
) (
  input  logic [N_IN-1:0]   arr_in,
  input  logic [2*N_IN-1:0] lits,
  output logic              pt
);
  logic [N_IN-1:0] lit_ok;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    // bit 0 asks for the true form, bit 1 for the complement; both together can never pass
    assign lit_ok[i] = (~lits[2*i] | arr_in[i]) & (~lits[2*i+1] | ~arr_in[i]);
  end

  assign pt = &lit_ok;
endmodule

// File: rtl/mc_route.sv
module mc_route
  import mc_pkg::*;
#(
  parameter int NUM_TERMS = 5
) (
  input  logic [NUM_TERMS-1:0]        pt,
  input  logic [NUM_TERMS*ROLE_W-1:0] roles,
  output logic                        sum_raw,
  output logic                        aux,
  output logic                        arr_clk,
  output logic                        en,
  output logic                        pre,
  output logic                        clr
);
  logic [NUM_TERMS-1:0] hit_sum, hit_aux, hit_clk, hit_en, hit_pre, hit_clr;
  logic [NUM_TERMS-1:0] owns_en;

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_route
    logic [ROLE_W-1:0] r;
    assign r          = roles[t*ROLE_W +: ROLE_W];
    assign hit_sum[t] = pt[t] & (r == ROLE_SUM);
    assign hit_aux[t] = pt[t] & (r == ROLE_AUX);
    assign hit_clk[t] = pt[t] & (r == ROLE_CLK);
    assign hit_en[t]  = pt[t] & (r == ROLE_EN);
    assign hit_pre[t] = pt[t] & (r == ROLE_PRE);
    assign hit_clr[t] = pt[t] & (r == ROLE_CLR);
    assign owns_en[t] = (r == ROLE_EN);
  end

  assign sum_raw = |hit_sum;
  assign aux     = |hit_aux;
  assign arr_clk = |hit_clk;
  assign en      = (|hit_en) | ~(|owns_en);
  assign pre     = |hit_pre;
  assign clr     = |hit_clr;
endmodule

// File: rtl/mc_clksel.sv
module mc_clksel
  import mc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GCLK-1:0] gclk_pin,
  input  logic [NUM_GCLK-1:0] cfg_gpin,
  input  logic [NUM_GCLK-1:0] cfg_ginv,
  input  logic                cfg_gsel,
  input  logic [1:0]          cfg_src,
  input  logic                arr_clk,
  input  logic                en,
  output logic                clk_rise,
  output logic                reg_upd
);
  logic [NUM_GCLK-1:0] gclk;
  logic                lvl, lvl_q;
  logic                use_array;

  for (genvar g = 0; g < NUM_GCLK; g++) begin : g_gclk
    assign gclk[g] = gclk_pin[cfg_gpin[g]] ^ cfg_ginv[g];
  end

  assign use_array = cfg_src[1];
  assign lvl       = use_array ? arr_clk : gclk[cfg_gsel];

  // Previous level starts high so a clock already high at reset release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl;
  end

  assign clk_rise = lvl & ~lvl_q;
  assign reg_upd  = clk_rise & (cfg_src != SRC_GATED || en);
endmodule

// File: rtl/mc_reg.sv
module mc_reg
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       upd,
  input  logic       a,
  input  logic       b,
  input  logic       pre,
  input  logic       clr,
  output logic       q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (pre) q <= 1'b1;
    else if (upd) q <= next_state(mode, a, b, q);
  end
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter int N_IN      = 8,
  parameter int NUM_TERMS = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_IN-1:0]               arr_in,
  input  logic [1:0]                    gclk_pin,
  input  logic                          gclr_n,
  input  logic [NUM_TERMS*2*N_IN-1:0]   cfg_lit,
  input  logic [NUM_TERMS*ROLE_W-1:0]   cfg_role,
  input  logic                          cfg_xor,
  input  logic [2:0]                    cfg_mode,
  input  logic [1:0]                    cfg_clk_src,
  input  logic [1:0]                    cfg_gpin,
  input  logic [1:0]                    cfg_ginv,
  input  logic                          cfg_gsel,
  input  logic                          cfg_gclr_en,
  output logic                          mc_out
);
  localparam int LIT_W = 2 * N_IN;

  // configuration shadow, loaded only while reset is held
  logic [NUM_TERMS*LIT_W-1:0]  lit_q;
  logic [NUM_TERMS*ROLE_W-1:0] role_q;
  logic                        xor_q, gsel_q, gclr_en_q;
  logic [2:0]                  mode_q;
  logic [1:0]                  src_q, gpin_q, ginv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lit_q     <= cfg_lit;
      role_q    <= cfg_role;
      xor_q     <= cfg_xor;
      mode_q    <= cfg_mode;
      src_q     <= cfg_clk_src;
      gpin_q    <= cfg_gpin;
      ginv_q    <= cfg_ginv;
      gsel_q    <= cfg_gsel;
      gclr_en_q <= cfg_gclr_en;
    end
  end

  // named internal events
  logic [NUM_TERMS-1:0] pt;
  logic sum_raw, sum_x, aux, arr_clk, en_act, pre_term, clr_term;
  logic clr_act, pre_act, clk_rise, reg_upd, registered, q_state, q_vis;

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    mc_term #(.N_IN(N_IN)) u_term (
      .arr_in (arr_in),
      .lits   (lit_q[t*LIT_W +: LIT_W]),
      .pt     (pt[t])
    );
  end

  mc_route #(.NUM_TERMS(NUM_TERMS)) u_route (
    .pt      (pt),
    .roles   (role_q),
    .sum_raw (sum_raw),
    .aux     (aux),
    .arr_clk (arr_clk),
    .en      (en_act),
    .pre     (pre_term),
    .clr     (clr_term)
  );

  assign sum_x      = sum_raw ^ xor_q;
  assign clr_act    = clr_term | (gclr_en_q & ~gclr_n);
  assign pre_act    = pre_term;
  assign registered = is_registered(mode_q);

  mc_clksel u_clksel (
    .clk      (clk),
    .rst_n    (rst_n),
    .gclk_pin (gclk_pin),
    .cfg_gpin (gpin_q),
    .cfg_ginv (ginv_q),
    .cfg_gsel (gsel_q),
    .cfg_src  (src_q),
    .arr_clk  (arr_clk),
    .en       (en_act),
    .clk_rise (clk_rise),
    .reg_upd  (reg_upd)
  );

  mc_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode_q),
    .upd   (reg_upd),
    .a     (sum_x),
    .b     (aux),
    .pre   (pre_act),
    .clr   (clr_act),
    .q     (q_state)
  );

  // asynchronous overrides reach the output without waiting for the register
  assign q_vis  = clr_act ? 1'b0 : (pre_act ? 1'b1 : q_state);
  assign mc_out = registered ? q_vis : sum_x;
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk
  import mc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_q,
  input logic [1:0] src_q,
  input logic       registered,
  input logic       clr_act,
  input logic       pre_act,
  input logic       reg_upd,
  input logic       en_act,
  input logic       sum_x,
  input logic       aux,
  input logic       q_state,
  input logic       mc_out
);
  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !registered |-> mc_out == sum_x);

  assert_d_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_D && reg_upd && !clr_act && !pre_act) |=> q_state == $past(sum_x));

  assert_t_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_T && reg_upd && sum_x && !clr_act && !pre_act) |=> q_state != $past(q_state));

  assert_jk_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_JK && reg_upd && sum_x && aux && !clr_act && !pre_act) |=> q_state != $past(q_state));

  assert_sr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SR && reg_upd && sum_x && aux && !clr_act && !pre_act) |=> $stable(q_state));

  assert_hold_no_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_upd && !clr_act && !pre_act) |=> $stable(q_state));

  assert_gate_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_GATED && !en_act && !clr_act && !pre_act) |=> $stable(q_state));

  assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (registered && clr_act) |-> mc_out == 1'b0);

  assert_preset_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (registered && pre_act && !clr_act) |-> mc_out == 1'b1);

  assert_clear_sticks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> q_state == 1'b0);
endmodule

bind mc_macrocell mc_macrocell_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_q     (mode_q),
  .src_q      (src_q),
  .registered (registered),
  .clr_act    (clr_act),
  .pre_act    (pre_act),
  .reg_upd    (reg_upd),
  .en_act     (en_act),
  .sum_x      (sum_x),
  .aux        (aux),
  .q_state    (q_state),
  .mc_out     (mc_out)
);

// File: tb/sim_mc_macrocell.sv
module sim_mc_macrocell;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8;
  localparam int NT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] arr_in = '0;
  logic [1:0] gclk_pin = '0;
  logic gclr_n = 1'b1;
  logic [NT*2*NI-1:0] cfg_lit = '0;
  logic [NT*3-1:0] cfg_role = '1;
  logic cfg_xor = 1'b0;
  logic [2:0] cfg_mode = '0;
  logic [1:0] cfg_clk_src = '0;
  logic [1:0] cfg_gpin = 2'b10;
  logic [1:0] cfg_ginv = '0;
  logic cfg_gsel = 1'b0;
  logic cfg_gclr_en = 1'b0;
  logic mc_out;

  int checks = 0;
  int errors = 0;
  logic [2*NI-1:0] tl [NT];
  logic [2:0] rl [NT];
  logic qm;  // bench model of the register

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_macrocell #(.N_IN(NI), .NUM_TERMS(NT)) u0 (.*);

  function automatic logic [2*NI-1:0] lt(int i); return (2*NI)'(1) << (2*i); endfunction
  function automatic logic [2*NI-1:0] lc(int i); return (2*NI)'(2) << (2*i); endfunction

  function automatic logic model_next(logic [2:0] m, logic a, logic b, logic q);
    if (m == 3'd1) return a;
    if (m == 3'd2) return a ? ~q : q;
    if (m == 3'd3) return (a && b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
    if (m == 3'd4) return (a && !b) ? 1'b1 : ((!a && b) ? 1'b0 : q);
    return q;
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic base_cfg();
    for (int t = 0; t < NT; t++) begin tl[t] = '0; rl[t] = 3'd6; end
    cfg_xor = 0; cfg_mode = 3'd0; cfg_clk_src = 2'd0; cfg_gpin = 2'b10;
    cfg_ginv = 2'b00; cfg_gsel = 0; cfg_gclr_en = 0;
    arr_in = '0; gclk_pin = 2'b00; gclr_n = 1'b1;
  endtask

  task automatic do_reset();
    for (int t = 0; t < NT; t++) begin
      cfg_lit[t*2*NI +: 2*NI] = tl[t];
      cfg_role[t*3 +: 3] = rl[t];
    end
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    qm = 1'b0;
  endtask

  task automatic pulse_pin(int p);
    gclk_pin[p] = ~gclk_pin[p]; tick();
    gclk_pin[p] = ~gclk_pin[p]; tick();
  endtask

  task automatic pulse_in(int b);
    arr_in[b] = 1'b1; tick();
    arr_in[b] = 1'b0; tick();
  endtask

  // R14: reset value, and no spurious edge from a clock already high at release
  task automatic t_reset();
    base_cfg(); tl[0] = lt(0); rl[0] = 3'd0; cfg_mode = 3'd1;
    gclk_pin[0] = 1'b1; arr_in[0] = 1'b1;
    do_reset();
    chk(mc_out, 1'b0, "R14 reset state");
    tick(); tick();
    chk(mc_out, 1'b0, "R9 no edge when clock high at reset release");
    gclk_pin[0] = 1'b0; tick();
  endtask

  // R1 R2 R3 R4: bypass path across all patterns of four inputs
  task automatic t_comb(input logic x);
    base_cfg(); cfg_xor = x;
    tl[0] = lt(0) | lc(1); rl[0] = 3'd0;
    tl[1] = lt(2);         rl[1] = 3'd0;
    tl[2] = lt(3) | lc(3); rl[2] = 3'd0;  // R1 code 11 forces 0
    tl[3] = '0;            rl[3] = 3'd6;  // unused role, would be 1
    do_reset();
    for (int v = 0; v < 16; v++) begin
      logic e;
      arr_in = 8'(v); #1;
      e = ((v[0] & ~v[1]) | v[2]) ^ x;
      chk(mc_out, e, x ? "R3 inverted sum" : "R4 R1 R2 sum of products");
      tick();
    end
    base_cfg(); tl[4] = '0; rl[4] = 3'd0; do_reset();
    arr_in = 8'hA5; #1;
    chk(mc_out, 1'b1, "R1 empty term is 1");
    base_cfg(); cfg_mode = 3'd6; tl[0] = lc(0); rl[0] = 3'd0; do_reset();
    arr_in = 8'h00; #1;
    chk(mc_out, 1'b1, "R4 spare mode code bypasses");
  endtask

  // R5 R9: D register on global clock 0
  task automatic t_dmode();
    logic [4:0] seq = 5'b01101;
    base_cfg(); tl[0] = lt(0); rl[0] = 3'd0; cfg_mode = 3'd1; do_reset();
    for (int k = 0; k < 5; k++) begin
      arr_in[0] = seq[k]; tick();
      pulse_pin(0);
      chk(mc_out, seq[k], "R5 D load");
    end
    qm = seq[4];
    arr_in[0] = ~qm; repeat (3) tick();
    chk(mc_out, qm, "R9 no update without edge");
    gclk_pin[0] = 1'b1; tick(); tick();
    chk(mc_out, ~qm, "R9 update on rising edge");
    arr_in[0] = qm; tick(); tick();
    chk(mc_out, ~qm, "R9 single update while clock held high");
    gclk_pin[0] = 1'b0; tick();
  endtask

  // R9: second global clock from the inverted second pin
  task automatic t_gsel();
    base_cfg(); tl[0] = lt(0); rl[0] = 3'd0; cfg_mode = 3'd1;
    cfg_gsel = 1'b1; cfg_ginv = 2'b10; gclk_pin = 2'b10;
    do_reset();
    arr_in[0] = 1'b1; tick();
    pulse_pin(0);
    chk(mc_out, 1'b0, "R9 unselected pin ignored");
    pulse_pin(1);
    chk(mc_out, 1'b1, "R9 inverted global clock");
  endtask

  // R6 R7 R8: T, JK and SR sequences compared with the bench model
  task automatic t_seq(input logic [2:0] m, input logic [9:0] ab, input string tag);
    base_cfg(); tl[0] = lt(0); rl[0] = 3'd0; tl[1] = lt(1); rl[1] = 3'd1;
    cfg_mode = m; do_reset();
    for (int k = 0; k < 5; k++) begin
      arr_in[0] = ab[2*k+1]; arr_in[1] = ab[2*k]; tick();
      pulse_pin(0);
      qm = model_next(m, ab[2*k+1], ab[2*k], qm);
      chk(mc_out, qm, tag);
    end
  endtask

  // R10: gated global clock
  task automatic t_gated();
    base_cfg(); tl[0] = lt(0); rl[0] = 3'd0; tl[2] = lt(4); rl[2] = 3'd3;
    cfg_mode = 3'd1; cfg_clk_src = 2'd1; do_reset();
    arr_in[0] = 1'b1; arr_in[4] = 1'b0; tick();
    pulse_pin(0);
    chk(mc_out, 1'b0, "R10 enable low blocks edge");
    arr_in[4] = 1'b1; tick();
    pulse_pin(0);
    chk(mc_out, 1'b1, "R10 enable high passes edge");
  endtask

  // R11: array clock from two ORed terms
  task automatic t_array();
    base_cfg(); tl[0] = lt(0); rl[0] = 3'd0;
    tl[3] = lt(5); rl[3] = 3'd2; tl[4] = lt(6); rl[4] = 3'd2;
    cfg_mode = 3'd1; cfg_clk_src = 2'd2; do_reset();
    arr_in[0] = 1'b1; tick();
    pulse_in(5);
    chk(mc_out, 1'b1, "R11 array clock term A");
    arr_in[0] = 1'b0; tick();
    pulse_in(6);
    chk(mc_out, 1'b0, "R11 array clock term B");
    arr_in[0] = 1'b1; tick();
    pulse_pin(0);
    chk(mc_out, 1'b0, "R11 global pin ignored");
  endtask

  // R12: preset and clear terms
  task automatic t_presclr();
    base_cfg(); tl[0] = lt(0); rl[0] = 3'd0;
    tl[2] = lt(4); rl[2] = 3'd4; tl[3] = lt(5); rl[3] = 3'd5;
    cfg_mode = 3'd1; do_reset();
    arr_in[4] = 1'b1; #1;
    chk(mc_out, 1'b1, "R12 preset immediate");
    tick(); arr_in[4] = 1'b0; #1;
    chk(mc_out, 1'b1, "R12 preset retained");
    arr_in[5] = 1'b1; #1;
    chk(mc_out, 1'b0, "R12 clear immediate");
    arr_in[4] = 1'b1; #1;
    chk(mc_out, 1'b0, "R12 clear wins over preset");
    tick(); arr_in[4] = 1'b0; arr_in[5] = 1'b0; tick();
    chk(mc_out, 1'b0, "R12 clear retained");
  endtask

  // R13: dedicated global clear, enabled and disabled
  task automatic t_gclr(input logic en);
    base_cfg(); tl[0] = lt(0); rl[0] = 3'd0; cfg_mode = 3'd1; cfg_gclr_en = en;
    do_reset();
    arr_in[0] = 1'b1; tick(); pulse_pin(0);
    gclr_n = 1'b0; #1;
    chk(mc_out, ~en, en ? "R13 global clear acts" : "R13 global clear ignored");
    tick(); gclr_n = 1'b1; tick();
    chk(mc_out, ~en, "R13 state after global clear");
  endtask

  // R14: configuration frozen after reset
  task automatic t_frozen();
    base_cfg(); tl[0] = lt(0); rl[0] = 3'd0; cfg_mode = 3'd1; do_reset();
    arr_in[0] = 1'b1; tick(); pulse_pin(0);
    cfg_mode = 3'd0; cfg_xor = 1'b1; cfg_role = '1; tick(); tick();
    chk(mc_out, 1'b1, "R14 mode change ignored");
    arr_in[0] = 1'b0; tick(); pulse_pin(0);
    chk(mc_out, 1'b0, "R14 still D after reset");
  endtask

  initial begin
    t_reset();
    t_comb(1'b0);
    t_comb(1'b1);
    t_dmode();
    t_gsel();
    t_seq(3'd2, 10'b10_10_00_10_00, "R6 T mode");
    t_seq(3'd3, 10'b10_00_01_11_11, "R7 JK mode");
    t_seq(3'd4, 10'b10_11_01_11_00, "R8 SR mode");
    t_gated();
    t_array();
    t_presclr();
    t_gclr(1'b1);
    t_gclr(1'b0);
    t_frozen();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule